// File: doc/BRIEF.md
# Strap-or-Serial Mode Configuration Port

This block sets a converter's operating modes from one of two sources that share the same four pins: chip select, serial clock, serial data in and serial data out. A separate mode-select input picks the meaning of those pins. When mode-select is high, the four pins are plain strap levels. The block decodes them directly into an output lane count, a sleep request and a reduced-drive-current flag. When mode-select is low, the same pins form a four-wire serial bus. That bus writes and reads back a small bank of 8-bit configuration registers. The whole bank is presented to neighbouring blocks as one flat vector. In this mode the three mode outputs are decoded from fields of register 0.

All pins are brought into the system clock domain through a two-flop synchroniser, and edges are detected there. The serial clock must therefore be slow compared with the system clock: each serial clock phase must last at least four system clocks. A serial frame is 16 bits long and is sent MSB first: a read flag, then a 7-bit address, then 8 data bits. A write takes effect only when the full frame has arrived before chip select returns high. During a read, the addressed byte is shifted out on the data-out pin while the last eight bits of the frame are clocked.

Top module: `cfg_port_top`

## Requirements
- R1: `mode_par_pin` high selects strap decoding for the three mode outputs; low selects decoding from register 0. The register contents are kept across any change of mode.
- R2: In strap mode, the two-bit code {`cs_n_pin`, `sck_pin`} sets `lane_count` as follows: 00 gives 2, 01 gives 4, 10 gives 1, and the reserved code 11 gives 0.
- R3: In strap mode, `sleep_req` follows `sdi_pin`: 1 requests sleep and 0 means normal operation.
- R4: In strap mode, `low_drive` follows `sdo_pin_in`: 0 selects the full (3.5 mA) drive and 1 selects the half (1.75 mA) drive.
- R5: In serial mode, a frame starts when `cs_n_pin` falls and ends when it rises. `sdi_pin` is captured on the first 16 rising edges of `sck_pin` only; any later rising edges in the same frame change nothing.
- R6: The frame is sent MSB first. Bit 15 is the read flag (1 = read, 0 = write), bits 14..8 are the register address, and bits 7..0 are the write data. A read frame leaves every register unchanged.
- R7: A write commits only when `cs_n_pin` rises after exactly 16 bits have been captured. A frame that ends with fewer bits changes no register.
- R8: In serial mode, the outputs are decoded from register 0 as follows: bits 1..0 give the lane code (same table as R2), bit 2 gives `sleep_req`, and bit 3 gives `low_drive`.
- R9: In a read frame, `sdo_pin_out` presents the addressed byte MSB first. Each bit is updated on the falling `sck_pin` edges that follow rising edges 8 through 15.
- R10: `sdo_pin_oe` is 1 only in serial mode while a frame is open (chip select low). It is 0 in strap mode and whenever chip select is high.
- R11: Addresses at or above `NUM_REGS` take no write, and a read from such an address returns zero.
- R12: A pin level present at clock edge n reaches the strap-mode outputs at edge n+2. A serial pin event sampled at edge n acts on the frame logic at edge n+2. A committing chip-select rise sampled at edge n updates `cfg_regs` at edge n+3 and the serial-mode outputs at edge n+4.
- R13: Synchronous reset clears every register to zero and sets `lane_count`=2, `sleep_req`=0, `low_drive`=0 and `sdo_pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par_pin | input | 1 | 1 = strap decoding, 0 = serial bus |
| cs_n_pin | input | 1 | Chip select (active low) / lane code MSB |
| sck_pin | input | 1 | Serial clock / lane code LSB |
| sdi_pin | input | 1 | Serial data in / sleep strap |
| sdo_pin_in | input | 1 | Data-out pin level read as drive strap |
| sdo_pin_out | output | 1 | Serial readback data |
| sdo_pin_oe | output | 1 | Output enable for the data-out pin |
| lane_count | output | 3 | Number of output lanes (0 = reserved) |
| sleep_req | output | 1 | Sleep request |
| low_drive | output | 1 | Half drive current select |
| cfg_regs | output | NUM_REGS*DATA_W | Register bank, register i at bits i*DATA_W upward |

## Verification
Strap mode is tried with all four lane codes, each crossed with both levels of the sleep and drive pins. This separates the reserved code from the valid ones and shows that each pin steers only its own output. Serial mode is tried with complete writes, reads, 12-bit short frames, frames carrying five extra clock edges, and an address beyond the bank. These show a commit apart from a discard, and show captured bits apart from ignored bits. A single-cycle pin step in strap mode pins down the two-edge latency. Switching back to strap mode after the serial writes confirms that the registers survive the change of mode.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    LANES_2    = 2'b00,
    LANES_4    = 2'b01,
    LANES_1    = 2'b10,
    LANES_RSVD = 2'b11
  } lane_code_e;

  // positions of the pins inside the synchronised bundle
  localparam int PIN_W    = 5;
  localparam int PIN_MODE = 4;
  localparam int PIN_CS   = 3;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SDI  = 1;
  localparam int PIN_SDO  = 0;

  // field layout of control register 0
  localparam int CTRL_LANE_LSB  = 0;
  localparam int CTRL_SLEEP_BIT = 2;
  localparam int CTRL_DRIVE_BIT = 3;

  function automatic logic [2:0] lanes_from_code(input logic [1:0] code);
    logic [2:0] n;
    case (lane_code_e'(code))
      LANES_2: n = 3'd2;
      LANES_4: n = 3'd4;
      LANES_1: n = 3'd1;
      default: n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2   // two or more
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              wr_in_range, rd_in_range;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_in_range = {1'b0, wr_addr} < LIMIT;
  assign rd_in_range = {1'b0, rd_addr} < LIMIT;
  assign wr_idx      = wr_addr[IDX_W-1:0];
  assign rd_idx      = rd_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && wr_in_range) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (rd_in_range) rd_data <= mem[rd_idx];
    else                  rd_data <= '0;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_flat
      assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
    end
  endgenerate

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_in_range) |=> $stable(regs_flat)); // R11

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_in_range |=> (rd_data == '0)); // R11

endmodule

// File: rtl/cfg_serial_engine.sv
module cfg_serial_engine #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR_DONE = CNT_W'(1 + ADDR_W);

  logic              cs_prev, sck_prev;
  logic              cs_fall, cs_rise, sck_rise, sck_fall;
  logic              active, is_read;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh, out_sh;
  logic              take_bit, in_rw_slot, in_addr_slot, in_read_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev  <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_n;
      sck_prev <= sck;
    end
  end

  always_comb begin
    cs_fall        = cs_prev & ~cs_n;
    cs_rise        = ~cs_prev & cs_n;
    sck_rise       = ~sck_prev & sck;
    sck_fall       = sck_prev & ~sck;
    in_rw_slot     = (cnt == '0);
    in_addr_slot   = (cnt != '0) && (cnt < CNT_ADDR_DONE);
    in_read_window = is_read && (cnt >= CNT_ADDR_DONE) && (cnt < CNT_FULL);
    take_bit       = !par_mode && !cs_fall && !cs_rise && active
                     && sck_rise && (cnt < CNT_FULL);
  end

  // frame control
  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst || par_mode) begin
      active <= 1'b0;
      cnt    <= '0;
      sdo_oe <= 1'b0;
    end else if (cs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      sdo_oe <= 1'b1;
    end else if (cs_rise) begin
      active <= 1'b0;
      sdo_oe <= 1'b0;
      if (active && (cnt == CNT_FULL) && !is_read) wr_en <= 1'b1;
    end else if (take_bit) begin
      cnt <= cnt + 1'b1;
    end
  end

  // capture datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      is_read <= 1'b0;
      addr_sh <= '0;
      data_sh <= '0;
    end else if (!par_mode && cs_fall) begin
      is_read <= 1'b0;
    end else if (take_bit) begin
      if (in_rw_slot)        is_read <= sdi;
      else if (in_addr_slot) addr_sh <= {addr_sh[ADDR_W-2:0], sdi};
      else                   data_sh <= {data_sh[DATA_W-2:0], sdi};
    end
  end

  // readback shifter
  always_ff @(posedge clk) begin
    if (rst || par_mode) begin
      sdo    <= 1'b0;
      out_sh <= '0;
    end else if (cs_fall) begin
      sdo    <= 1'b0;
    end else if (!cs_rise && active && sck_fall && in_read_window) begin
      if (cnt == CNT_ADDR_DONE) begin
        sdo    <= rd_data[DATA_W-1];
        out_sh <= {rd_data[DATA_W-2:0], 1'b0};
      end else begin
        sdo    <= out_sh[DATA_W-1];
        out_sh <= {out_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign rd_addr = addr_sh;
  assign wr_addr = addr_sh;
  assign wr_data = data_sh;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL); // R5

  AST_EXTRA_EDGES_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && active && (cnt == CNT_FULL) && !cs_fall && !cs_rise)
      |=> ((cnt == CNT_FULL) && $stable(data_sh) && $stable(addr_sh))); // R5

  AST_COMMIT_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (($past(cnt) == CNT_FULL) && !$past(is_read))); // R7

  AST_OE_OFF_PARALLEL: assert property (@(posedge clk) disable iff (rst)
    par_mode |=> !sdo_oe); // R10

  AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cs_prev) |=> !sdo_oe); // R10

endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_par_pin,
  input  logic                       cs_n_pin,
  input  logic                       sck_pin,
  input  logic                       sdi_pin,
  input  logic                       sdo_pin_in,
  output logic                       sdo_pin_out,
  output logic                       sdo_pin_oe,
  output logic [2:0]                 lane_count,
  output logic                       sleep_req,
  output logic                       low_drive,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

  logic [PIN_W-1:0]  pins_raw, pins_s;
  logic              par_s, cs_s, sck_s, sdi_s, sdo_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data, ctrl_reg;
  logic              wr_en;
  logic [1:0]        lane_code_sel;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_MODE] = mode_par_pin;
    pins_raw[PIN_CS]   = cs_n_pin;
    pins_raw[PIN_SCK]  = sck_pin;
    pins_raw[PIN_SDI]  = sdi_pin;
    pins_raw[PIN_SDO]  = sdo_pin_in;
  end

  cfg_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign par_s = pins_s[PIN_MODE];
  assign cs_s  = pins_s[PIN_CS];
  assign sck_s = pins_s[PIN_SCK];
  assign sdi_s = pins_s[PIN_SDI];
  assign sdo_s = pins_s[PIN_SDO];

  cfg_serial_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .par_mode (par_s),
    .cs_n     (cs_s),
    .sck      (sck_s),
    .sdi      (sdi_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdo_pin_out),
    .sdo_oe   (sdo_pin_oe)
  );

  cfg_reg_file #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs)
  );

  assign ctrl_reg      = cfg_regs[DATA_W-1:0];
  assign lane_code_sel = par_s ? {cs_s, sck_s} : ctrl_reg[CTRL_LANE_LSB +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_count <= lanes_from_code(LANES_2);
      sleep_req  <= 1'b0;
      low_drive  <= 1'b0;
    end else begin
      lane_count <= lanes_from_code(lane_code_sel);
      sleep_req  <= par_s ? sdi_s : ctrl_reg[CTRL_SLEEP_BIT];
      low_drive  <= par_s ? sdo_s : ctrl_reg[CTRL_DRIVE_BIT];
    end
  end

  AST_RSVD_LANES: assert property (@(posedge clk) disable iff (rst)
    (par_s && cs_s && sck_s) |=> (lane_count == 3'd0)); // R2

  AST_STRAP_DRIVE: assert property (@(posedge clk) disable iff (rst)
    par_s |=> (low_drive == $past(sdo_s))); // R4

  AST_SERIAL_SLEEP_FIELD: assert property (@(posedge clk) disable iff (rst)
    !par_s |=> (sleep_req == $past(cfg_regs[CTRL_SLEEP_BIT]))); // R8

  AST_LANES_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_count) <= 1); // R2

endmodule

// File: tb/cfg_port_top_tb.sv
module cfg_port_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 8;
  localparam int DATA_W     = 8;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_par_pin = 1'b1, cs_n_pin = 1'b1, sck_pin = 1'b0, sdi_pin = 1'b0, sdo_pin_in = 1'b0;
  logic sdo_pin_out, sdo_pin_oe, sleep_req, low_drive;
  logic [2:0] lane_count;
  logic [NUM_REGS*DATA_W-1:0] cfg_regs;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_top #(.NUM_REGS(NUM_REGS), .ADDR_W(7), .DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .mode_par_pin(mode_par_pin), .cs_n_pin(cs_n_pin),
    .sck_pin(sck_pin), .sdi_pin(sdi_pin), .sdo_pin_in(sdo_pin_in),
    .sdo_pin_out(sdo_pin_out), .sdo_pin_oe(sdo_pin_oe), .lane_count(lane_count),
    .sleep_req(sleep_req), .low_drive(low_drive), .cfg_regs(cfg_regs)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lanes_of(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  // pins kept as {mode, cs, sck, sdi, sdo}, history by clock edge
  logic [4:0] h1, h2, h3;
  int  mem [NUM_REGS];
  int  m_lanes, m_sleep, m_low, m_sdo, m_oe;
  int  m_active, m_cnt, m_wr, m_wa, m_wd;
  logic [15:0] m_word;

  always @(posedge clk) begin
    if (rst) begin
      h1 = '0; h2 = '0; h3 = '0;
      for (int i = 0; i < NUM_REGS; i++) mem[i] = 0;
      m_lanes = 2; m_sleep = 0; m_low = 0; m_sdo = 0; m_oe = 0;
      m_active = 0; m_cnt = 0; m_wr = 0; m_wa = 0; m_wd = 0; m_word = '0;
    end else begin
      // mode outputs (R1..R4, R8) from pins two edges old or from register 0
      if (h2[4]) begin
        m_lanes = lanes_of({h2[3], h2[2]});
        m_sleep = h2[1];
        m_low   = h2[0];
      end else begin
        m_lanes = lanes_of(mem[0] & 3);
        m_sleep = (mem[0] >> 2) & 1;
        m_low   = (mem[0] >> 3) & 1;
      end
      // pending write lands
      if (m_wr != 0) begin
        if (m_wa < NUM_REGS) mem[m_wa] = m_wd;
        m_wr = 0;
      end
      // frame behaviour
      if (h2[4]) begin
        m_active = 0; m_cnt = 0; m_sdo = 0; m_oe = 0;
      end else if (h3[3] && !h2[3]) begin
        m_active = 1; m_cnt = 0; m_oe = 1; m_sdo = 0; m_word = '0;
      end else if (!h3[3] && h2[3]) begin
        m_oe = 0;
        if (m_active != 0 && m_cnt == 16 && !m_word[15]) begin
          m_wr = 1; m_wa = int'(m_word[14:8]); m_wd = int'(m_word[7:0]);
        end
        m_active = 0;
      end else if (m_active != 0) begin
        if (!h3[2] && h2[2] && m_cnt < 16) begin
          m_word[15-m_cnt] = h2[1];
          m_cnt++;
        end
        if (h3[2] && !h2[2] && m_cnt >= 8 && m_cnt < 16 && m_word[15]) begin
          if (int'(m_word[14:8]) < NUM_REGS) m_sdo = (mem[int'(m_word[14:8])] >> (15 - m_cnt)) & 1;
          else m_sdo = 0;
        end
      end
      h3 = h2; h2 = h1;
      h1 = {mode_par_pin, cs_n_pin, sck_pin, sdi_pin, sdo_pin_in};
    end
  end

  // compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R8 lane_count", int'(lane_count), m_lanes);
      chk("R3/R8 sleep_req", int'(sleep_req), m_sleep);
      chk("R4/R8 low_drive", int'(low_drive), m_low);
      chk("R10 sdo_pin_oe", int'(sdo_pin_oe), m_oe);
      if (sdo_pin_oe) chk("R9 sdo_pin_out", int'(sdo_pin_out), m_sdo);
      for (int i = 0; i < NUM_REGS; i++)
        chk("R7 cfg_regs", int'(cfg_regs[i*DATA_W +: DATA_W]), mem[i]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_straps(input logic c, input logic s, input logic d, input logic o);
    @(negedge clk);
    cs_n_pin = c; sck_pin = s; sdi_pin = d; sdo_pin_in = o;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra,
                       output logic [7:0] rb);
    rb = '0;
    @(negedge clk);
    cs_n_pin = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < nbits + extra; i++) begin
      sdi_pin = (i < nbits) ? w[15-i] : 1'b1;
      wait_cyc(HALF);
      sck_pin = 1'b1;
      wait_cyc(HALF);
      sck_pin = 1'b0;
      if (i >= 7 && i <= 14) begin
        wait_cyc(HALF - 1);
        rb[14-i] = sdo_pin_out;
      end
    end
    wait_cyc(HALF);
    cs_n_pin = 1'b1;
    wait_cyc(2 * HALF);
  endtask

  logic [7:0] rb;

  initial begin
    rst = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    // R13 reset state, before the first pin level has been synchronised
    chk("R13 lane_count", int'(lane_count), 2);
    chk("R13 sleep_req", int'(sleep_req), 0);
    chk("R13 oe", int'(sdo_pin_oe), 0);
    chk("R13 regs", int'(cfg_regs[7:0]), 0);
    wait_cyc(4);

    // strap patterns: every lane code crossed with the sleep and drive pins
    for (int code = 0; code < 4; code++) begin
      for (int sd = 0; sd < 4; sd++) begin
        set_straps(code[1], code[0], sd[1], sd[0]);
        wait_cyc(4);
        chk("R2 strap lanes", int'(lane_count), lanes_of(code));
        chk("R3 strap sleep", int'(sleep_req), sd / 2);
        chk("R4 strap drive", int'(low_drive), sd % 2);
        chk("R10 oe strap", int'(sdo_pin_oe), 0);
      end
    end

    // R12 latency: step sdi at the negedge before edge k, outputs move at k+2
    set_straps(1'b0, 1'b0, 1'b0, 1'b0);
    wait_cyc(4);
    @(negedge clk); sdi_pin = 1'b1;
    wait_cyc(2);
    chk("R12 not yet at k+1", int'(sleep_req), 0);
    wait_cyc(1);
    chk("R12 visible at k+2", int'(sleep_req), 1);

    // switch to serial mode with bus idle
    set_straps(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); mode_par_pin = 1'b0;
    wait_cyc(6);
    chk("R1 serial uses reg0 lanes", int'(lane_count), 2);
    chk("R1 serial uses reg0 sleep", int'(sleep_req), 0);
    chk("R10 oe idle", int'(sdo_pin_oe), 0);

    // R6/R8 write register 0: lane code 01, sleep, half drive = 0x0D
    frame({1'b0, 7'd0, 8'h0D}, 16, 0, rb);
    chk("R8 lanes from reg0", int'(lane_count), 4);
    chk("R8 sleep from reg0", int'(sleep_req), 1);
    chk("R8 drive from reg0", int'(low_drive), 1);

    // R9 write then read register 3
    frame({1'b0, 7'd3, 8'hA5}, 16, 0, rb);
    chk("R7 reg3 written", int'(cfg_regs[3*8 +: 8]), 8'hA5);
    frame({1'b1, 7'd3, 8'h00}, 16, 0, rb);
    chk("R9 readback reg3", int'(rb), 8'hA5);
    chk("R6 read leaves reg3", int'(cfg_regs[3*8 +: 8]), 8'hA5);

    // R7 short frame discarded
    frame({1'b0, 7'd3, 8'h3C}, 12, 0, rb);
    chk("R7 short frame no write", int'(cfg_regs[3*8 +: 8]), 8'hA5);

    // R5 extra clock edges ignored
    frame({1'b0, 7'd5, 8'h96}, 16, 5, rb);
    chk("R5 extra edges ignored", int'(cfg_regs[5*8 +: 8]), 8'h96);
    frame({1'b1, 7'd5, 8'h00}, 16, 0, rb);
    chk("R9 readback reg5", int'(rb), 8'h96);

    // R11 out-of-range address
    frame({1'b0, 7'h40, 8'hFF}, 16, 0, rb);
    for (int i = 0; i < NUM_REGS; i++)
      chk("R11 no write beyond bank", int'(cfg_regs[i*8 +: 8]),
          (i == 0) ? 8'h0D : (i == 3) ? 8'hA5 : (i == 5) ? 8'h96 : 0);
    frame({1'b1, 7'h40, 8'h00}, 16, 0, rb);
    chk("R11 read beyond bank zero", int'(rb), 0);

    // R6 read of register 0
    frame({1'b1, 7'd0, 8'h00}, 16, 0, rb);
    chk("R6 readback reg0", int'(rb), 8'h0D);

    // reserved lane code via register 0
    frame({1'b0, 7'd0, 8'h03}, 16, 0, rb);
    chk("R8 reserved lanes", int'(lane_count), 0);

    // R1 back to strap mode: registers kept, outputs follow pins
    @(negedge clk); mode_par_pin = 1'b1;
    set_straps(1'b1, 1'b0, 1'b0, 1'b1);
    wait_cyc(6);
    chk("R1 strap lanes after serial", int'(lane_count), 1);
    chk("R1 strap drive after serial", int'(low_drive), 1);
    chk("R1 regs retained", int'(cfg_regs[3*8 +: 8]), 8'hA5);
    chk("R10 oe strap cs low", int'(sdo_pin_oe), 0);

    wait_cyc(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule